// File: doc/BRIEF.md
# Parallel Display Bus Cycle Engine

This block is the host end of an 8-bit parallel bus with a register-select line, a read/write line and an enable strobe. It is used to talk to a character display controller. A single request carries a register select, a direction and a write byte. The engine turns that request into one or two enable strobes. Every setup, hold, pulse-width and cycle-period minimum is met as a whole number of clock cycles. Each minimum is derived at elaboration time from a nanosecond parameter and the clock period, with rounding up. Read data is captured while the strobe is high and is returned together with a single-cycle completion pulse.

The engine has two bus widths. In wide mode each byte moves in one strobe. In narrow mode each byte moves as two strobes on the upper four data lines, high half first. An optional busy-wait can also be set per request. Before a write is issued, the engine repeats status reads (register select 0, read) until the busy bit reads 0. The busy bit is data line 7. The bus width and busy-wait setting are sampled when a request is accepted.

Top module: `dispbus_engine`

## Requirements
- R1: During and after reset, with no request, the enable strobe and the data output-enable are low, `done` is low, `req_ready` is high and `rd_data` is 0.
- R2: The enable strobe stays high for at least ceil(T_EHIGH_NS/CLK_NS) cycles, which is 28 cycles at the default values.
- R3: Register select and read/write hold the same value for at least one cycle before the strobe rises. They stay unchanged while the strobe is high and for at least one cycle after it falls.
- R4: From one rising edge of the strobe to the next there are at least ceil(T_CYCLE_NS/CLK_NS) cycles, which is 240 at the default values.
- R5: The data output-enable is never high while read/write is 1. During a write it is high for the whole strobe and on the cycle after the strobe falls, and the driven data stays unchanged while the strobe is high.
- R6: Read data is taken from the data lines in the last cycle of the strobe-high phase. At defaults that is at least 100 ns after the rising edge.
- R7: In wide mode (`nibble_mode`=0) a request makes exactly one strobe, and a write drives the whole byte on data lines 7..0.
- R8: In narrow mode (`nibble_mode`=1) a request makes two strobes. A write drives bits 7..4 first and then bits 3..0, each on data lines 7..4, with lines 3..0 driven 0. A read puts the first strobe's lines 7..4 into `rd_data[7:4]` and the second strobe's lines 7..4 into `rd_data[3:0]`.
- R9: With `poll_busy`=1, a write is preceded by status reads (select 0, read) until line 7 of a status read is 0. In narrow mode each status read is a full pair of strobes, and the busy bit is taken from the first strobe. Busy-wait never applies to reads.
- R10: `req_ready` goes low on the cycle after a request is accepted. `done` pulses for exactly one cycle when the request ends, and `req_ready` is high again after it. `rd_data` takes the read value on a read, together with `done`.
- R11: With `poll_busy`=0 no status read is issued before a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_rs | input | 1 | Register select for the request |
| req_rw | input | 1 | 1 read, 0 write |
| req_data | input | 8 | Write byte |
| nibble_mode | input | 1 | 1 selects two 4-bit strobes per byte |
| poll_busy | input | 1 | 1 waits on the busy bit before writes |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte read by the last read request |
| bus_rs | output | 1 | Register select pin |
| bus_rw | output | 1 | Read/write pin |
| bus_e | output | 1 | Enable strobe pin |
| bus_dout | output | 8 | Data pins, driven value |
| bus_oe | output | 1 | Data pin output-enable |
| bus_din | input | 8 | Data pins, sensed value |

## Verification
The bound checker watches the pin timing on every cycle. It checks the strobe width, the period between rising edges, the stability of select and direction around the strobe, and output-enable being confined to writes. It also checks the single-cycle `done` and the drop of `req_ready` after acceptance. The ordering of the narrow-mode halves, the zeroed low data lines, the number of status reads that a given busy sequence costs, and the assembled read bytes depend on the device's answers. Only the bench scenarios show those, using a device model that returns stale data until 100 ns into each strobe.

// File: rtl/dispbus_pkg.sv
`timescale 1ns/1ps
package dispbus_pkg;
  localparam int BUS_W = 8;
  localparam int NIB_W = BUS_W / 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD, PH_PAD
  } strobe_ph_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_POLL_A, SQ_POLL_B, SQ_XFER_A, SQ_XFER_B
  } seq_st_t;

  typedef struct packed {
    logic             rs;
    logic             rw;
    logic [BUS_W-1:0] val;
  } strobe_req_t;

  // Nanoseconds to clock cycles, rounded up.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dispbus_strobe.sv
`timescale 1ns/1ps
// One timed strobe: setup, high, hold, then padding up to the cycle minimum.
module dispbus_strobe
  import dispbus_pkg::*;
#(
  parameter int SETUP_C = 1,
  parameter int HIGH_C  = 28,
  parameter int HOLD_C  = 2,
  parameter int PAD_C   = 209,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  strobe_req_t      req,
  output logic             done,
  output logic [BUS_W-1:0] rd_val,
  output logic             bus_rs,
  output logic             bus_rw,
  output logic             bus_e,
  output logic [BUS_W-1:0] bus_dout,
  output logic             bus_oe,
  input  logic [BUS_W-1:0] bus_din
);
  strobe_ph_t       ph;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      rd_val   <= '0;
      bus_rs   <= 1'b0;
      bus_rw   <= 1'b0;
      bus_e    <= 1'b0;
      bus_dout <= '0;
      bus_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (go) begin
            bus_rs   <= req.rs;
            bus_rw   <= req.rw;
            bus_dout <= req.rw ? '0 : req.val;
            bus_oe   <= !req.rw;
            cnt      <= CNT_W'(SETUP_C - 1);
            ph       <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            bus_e <= 1'b1;
            cnt   <= CNT_W'(HIGH_C - 1);
            ph    <= PH_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            bus_e  <= 1'b0;
            rd_val <= bus_din;
            cnt    <= CNT_W'(HOLD_C - 1);
            ph     <= PH_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            bus_oe <= 1'b0;
            if (PAD_C > 0) begin
              cnt <= CNT_W'(PAD_C - 1);
              ph  <= PH_PAD;
            end else begin
              done <= 1'b1;
              ph   <= PH_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_PAD: begin
          if (cnt == '0) begin
            done <= 1'b1;
            ph   <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dispbus_seq.sv
`timescale 1ns/1ps
// Request sequencer: busy polling, nibble splitting and read assembly.
module dispbus_seq
  import dispbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_rs,
  input  logic             req_rw,
  input  logic [BUS_W-1:0] req_data,
  input  logic             nibble_mode,
  input  logic             poll_busy,
  output logic             st_go,
  output strobe_req_t      st_req,
  input  logic             st_done,
  input  logic [BUS_W-1:0] st_rd,
  output logic             done,
  output logic [BUS_W-1:0] rd_data
);
  seq_st_t          st;
  logic             t_rs, t_rw, t_nib, busy_seen;
  logic [BUS_W-1:0] t_data;
  logic [NIB_W-1:0] rd_hi;

  assign req_ready = (st == SQ_IDLE);

  always_comb begin
    st_req = '{rs: 1'b0, rw: 1'b1, val: '0};
    case (st)
      SQ_XFER_A: begin
        st_req.rs  = t_rs;
        st_req.rw  = t_rw;
        st_req.val = t_nib ? {t_data[BUS_W-1:NIB_W], {NIB_W{1'b0}}} : t_data;
      end
      SQ_XFER_B: begin
        st_req.rs  = t_rs;
        st_req.rw  = t_rw;
        st_req.val = {t_data[NIB_W-1:0], {NIB_W{1'b0}}};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      st_go     <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
      t_rs      <= 1'b0;
      t_rw      <= 1'b0;
      t_nib     <= 1'b0;
      t_data    <= '0;
      busy_seen <= 1'b0;
      rd_hi     <= '0;
    end else begin
      st_go <= 1'b0;
      done  <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (req_valid) begin
            t_rs   <= req_rs;
            t_rw   <= req_rw;
            t_nib  <= nibble_mode;
            t_data <= req_data;
            st_go  <= 1'b1;
            st     <= (!req_rw && poll_busy) ? SQ_POLL_A : SQ_XFER_A;
          end
        end
        SQ_POLL_A: begin
          if (st_done) begin
            busy_seen <= st_rd[BUS_W-1];
            st_go     <= 1'b1;
            if (t_nib)               st <= SQ_POLL_B;
            else if (st_rd[BUS_W-1]) st <= SQ_POLL_A;
            else                     st <= SQ_XFER_A;
          end
        end
        SQ_POLL_B: begin
          if (st_done) begin
            st_go <= 1'b1;
            st    <= busy_seen ? SQ_POLL_A : SQ_XFER_A;
          end
        end
        SQ_XFER_A: begin
          if (st_done) begin
            if (t_nib) begin
              rd_hi <= st_rd[BUS_W-1:NIB_W];
              st_go <= 1'b1;
              st    <= SQ_XFER_B;
            end else begin
              if (t_rw) rd_data <= st_rd;
              done <= 1'b1;
              st   <= SQ_IDLE;
            end
          end
        end
        SQ_XFER_B: begin
          if (st_done) begin
            if (t_rw) rd_data <= {rd_hi, st_rd[BUS_W-1:NIB_W]};
            done <= 1'b1;
            st   <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dispbus_engine.sv
`timescale 1ns/1ps
module dispbus_engine
  import dispbus_pkg::*;
#(
  parameter int CLK_NS           = 5,
  parameter int T_CYCLE_NS       = 1200,
  parameter int T_EHIGH_NS       = 140,
  parameter int T_ADDR_SETUP_NS  = 0,
  parameter int T_ADDR_HOLD_NS   = 10,
  parameter int T_DATA_SETUP_NS  = 40,
  parameter int T_DATA_HOLD_NS   = 10,
  parameter int T_READ_DELAY_NS  = 100,
  parameter int CNT_W            = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_rs,
  input  logic             req_rw,
  input  logic [BUS_W-1:0] req_data,
  input  logic             nibble_mode,
  input  logic             poll_busy,
  output logic             done,
  output logic [BUS_W-1:0] rd_data,
  output logic             bus_rs,
  output logic             bus_rw,
  output logic             bus_e,
  output logic [BUS_W-1:0] bus_dout,
  output logic             bus_oe,
  input  logic [BUS_W-1:0] bus_din
);
  localparam int SETUP_C = imax(1, ns_to_cyc(T_ADDR_SETUP_NS, CLK_NS));
  localparam int HIGH_C  = imax(imax(ns_to_cyc(T_EHIGH_NS, CLK_NS),
                                     ns_to_cyc(T_DATA_SETUP_NS, CLK_NS)),
                                ns_to_cyc(T_READ_DELAY_NS, CLK_NS) + 1);
  localparam int HOLD_C  = imax(1, imax(ns_to_cyc(T_ADDR_HOLD_NS, CLK_NS),
                                        ns_to_cyc(T_DATA_HOLD_NS, CLK_NS)));
  localparam int BASE_C  = SETUP_C + HIGH_C + HOLD_C;
  localparam int CYC_C   = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int PAD_C   = (CYC_C > BASE_C) ? (CYC_C - BASE_C) : 0;

  logic             st_go, st_done;
  strobe_req_t      st_req;
  logic [BUS_W-1:0] st_rd;

  dispbus_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_rs     (req_rs),
    .req_rw     (req_rw),
    .req_data   (req_data),
    .nibble_mode(nibble_mode),
    .poll_busy  (poll_busy),
    .st_go      (st_go),
    .st_req     (st_req),
    .st_done    (st_done),
    .st_rd      (st_rd),
    .done       (done),
    .rd_data    (rd_data)
  );

  dispbus_strobe #(
    .SETUP_C(SETUP_C),
    .HIGH_C (HIGH_C),
    .HOLD_C (HOLD_C),
    .PAD_C  (PAD_C),
    .CNT_W  (CNT_W)
  ) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .go      (st_go),
    .req     (st_req),
    .done    (st_done),
    .rd_val  (st_rd),
    .bus_rs  (bus_rs),
    .bus_rw  (bus_rw),
    .bus_e   (bus_e),
    .bus_dout(bus_dout),
    .bus_oe  (bus_oe),
    .bus_din (bus_din)
  );
endmodule

// File: rtl/dispbus_engine_chk.sv
`timescale 1ns/1ps
module dispbus_engine_chk
  import dispbus_pkg::*;
#(
  parameter int CLK_NS     = 5,
  parameter int T_CYCLE_NS = 1200,
  parameter int T_EHIGH_NS = 140
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic             bus_rs,
  input logic             bus_rw,
  input logic             bus_e,
  input logic             bus_oe,
  input logic [BUS_W-1:0] bus_dout
);
  localparam int E_MIN   = ns_to_cyc(T_EHIGH_NS, CLK_NS);
  localparam int CYC_MIN = ns_to_cyc(T_CYCLE_NS, CLK_NS);

  logic [15:0] hi_cnt, per_cnt;
  logic        e_q, seen_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      per_cnt   <= '0;
      e_q       <= 1'b0;
      seen_rise <= 1'b0;
    end else begin
      e_q <= bus_e;
      if (!bus_e) hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      if (bus_e && !e_q) begin
        per_cnt   <= 16'd1;
        seen_rise <= 1'b1;
      end else if (per_cnt != 16'hFFFF) begin
        per_cnt <= per_cnt + 1'b1;
      end
    end
  end

  a_r2_e_width: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_e) |-> hi_cnt >= 16'(E_MIN));

  a_r4_cycle_period: assert property (@(posedge clk) disable iff (rst)
    (bus_e && !e_q && seen_rise) |-> per_cnt >= 16'(CYC_MIN));

  a_r3_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_e) |-> ($stable(bus_rs) && $stable(bus_rw)));

  a_r3_stable_high: assert property (@(posedge clk) disable iff (rst)
    (bus_e && $past(bus_e)) |-> ($stable(bus_rs) && $stable(bus_rw)));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_e) |-> ($stable(bus_rs) && $stable(bus_rw)));

  a_r5_oe_write_only: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !bus_rw);

  a_r5_oe_in_write: assert property (@(posedge clk) disable iff (rst)
    (bus_e && !bus_rw) |-> bus_oe);

  a_r5_data_hold: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_e) && !bus_rw) |-> (bus_oe && $stable(bus_dout)));

  a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_e && $past(bus_e)) |-> $stable(bus_dout));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind dispbus_engine dispbus_engine_chk #(
  .CLK_NS    (CLK_NS),
  .T_CYCLE_NS(T_CYCLE_NS),
  .T_EHIGH_NS(T_EHIGH_NS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .bus_rs   (bus_rs),
  .bus_rw   (bus_rw),
  .bus_e    (bus_e),
  .bus_oe   (bus_oe),
  .bus_dout (bus_dout)
);

// File: tb/dispbus_engine_test.sv
`timescale 1ns/1ps
module dispbus_engine_test;
  localparam int E_MIN   = 28;
  localparam int CYC_MIN = 240;
  localparam int DLY_C   = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_rs = 1'b0, req_rw = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic       nibble_mode = 1'b0, poll_busy = 1'b0;
  logic       req_ready, done, bus_rs, bus_rw, bus_e, bus_oe;
  logic [7:0] rd_data, bus_dout, bus_din;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dispbus_engine uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_rw(req_rw), .req_data(req_data),
    .nibble_mode(nibble_mode), .poll_busy(poll_busy), .done(done),
    .rd_data(rd_data), .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_e(bus_e),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  // Device model state
  int         dev_busy_left = 0;
  logic [6:0] dev_ac = 7'h00;
  logic [7:0] dev_rdbyte = 8'h00;
  logic       dev_nib = 1'b0, dev_phase = 1'b0;
  int         e_hi = 0;
  logic [7:0] dev_word, nib_word;

  always_comb begin
    dev_word = bus_rs ? dev_rdbyte : {(dev_busy_left > 0), dev_ac};
    if (!dev_nib)       nib_word = dev_word;
    else if (dev_phase) nib_word = {dev_word[3:0], 4'h0};
    else                nib_word = {dev_word[7:4], 4'h0};
    bus_din = (bus_e && bus_rw && e_hi >= DLY_C) ? nib_word : ~nib_word;
  end

  // Strobe log
  logic [7:0] lg_val[64];
  logic       lg_rs[64], lg_rw[64];
  int         log_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Pin monitor, sampled away from the active edge
  logic e_prev = 1'b0, rs_prev = 1'b0, rw_prev = 1'b0, have_rise = 1'b0;
  int   since_rise = 0;
  always @(negedge clk) begin
    if (!rst) begin
      since_rise++;
      if (bus_e && !e_prev) begin
        if (have_rise) chk(since_rise >= CYC_MIN, "R4", "strobe period", since_rise, CYC_MIN);
        since_rise = 0;
        have_rise  = 1'b1;
      end
      if ((bus_e || e_prev) && (bus_rs != rs_prev || bus_rw != rw_prev))
        chk(1'b0, "R3", "select/direction moved near strobe", {bus_rs, bus_rw}, {rs_prev, rw_prev});
      if (bus_e && (bus_oe != !bus_rw))
        chk(1'b0, "R5", "output-enable during strobe", bus_oe, !bus_rw);
      if (!bus_e && e_prev) begin
        chk(e_hi >= E_MIN, "R2", "strobe width", e_hi, E_MIN);
        if (log_n < 64) begin
          lg_val[log_n] = bus_dout;
          lg_rs[log_n]  = bus_rs;
          lg_rw[log_n]  = bus_rw;
        end
        log_n++;
        if (!bus_rs && bus_rw && (!dev_nib || !dev_phase) && dev_busy_left > 0)
          dev_busy_left--;
        if (dev_nib) dev_phase = ~dev_phase;
      end
      e_hi = bus_e ? e_hi + 1 : 0;
    end
    e_prev  = bus_e;
    rs_prev = bus_rs;
    rw_prev = bus_rw;
  end

  task automatic run_txn(input logic rs, input logic rw, input logic [7:0] data,
                         input logic nib, input logic poll, input int busy_n);
    int n_poll, n_acc, cyc;
    logic [7:0] exp_rd, exp_v;
    @(negedge clk);
    dev_busy_left = busy_n;
    dev_nib       = nib;
    dev_phase     = 1'b0;
    dev_rdbyte    = 8'($urandom);
    dev_ac        = 7'($urandom);
    log_n         = 0;
    exp_rd = rs ? dev_rdbyte : {(busy_n > 0), dev_ac};
    chk(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_rs = rs; req_rw = rw; req_data = data;
    nibble_mode = nib; poll_busy = poll;
    @(negedge clk);
    req_valid = 1'b0;
    nibble_mode = $urandom; poll_busy = $urandom; req_data = 8'($urandom);
    chk(req_ready == 1'b0, "R10", "ready after accept", req_ready, 0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R10", "done pulse seen", done, 1);
    n_poll = (poll && !rw) ? (busy_n + 1) * (nib ? 2 : 1) : 0;
    n_acc  = nib ? 2 : 1;
    if (rw) begin
      chk(rd_data == exp_rd, nib ? "R8" : "R6", "read byte", rd_data, exp_rd);
    end
    chk(log_n == n_poll + n_acc, poll ? "R9" : "R11", "strobe count", log_n, n_poll + n_acc);
    chk(log_n == n_poll + n_acc, nib ? "R8" : "R7", "strobes per byte", log_n, n_poll + n_acc);
    if (log_n == n_poll + n_acc) begin
      for (int i = 0; i < n_poll; i++)
        chk(!lg_rs[i] && lg_rw[i], "R9", "status read strobe", {lg_rs[i], lg_rw[i]}, 1);
      for (int i = 0; i < n_acc; i++) begin
        chk(lg_rs[n_poll+i] == rs && lg_rw[n_poll+i] == rw, nib ? "R8" : "R7",
            "access select/direction", {lg_rs[n_poll+i], lg_rw[n_poll+i]}, {rs, rw});
        if (!rw) begin
          if (!nib)    exp_v = data;
          else if (i == 0) exp_v = {data[7:4], 4'h0};
          else         exp_v = {data[3:0], 4'h0};
          chk(lg_val[n_poll+i] == exp_v, nib ? "R8" : "R7", "write value",
              lg_val[n_poll+i], exp_v);
        end
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", "done lasts one cycle", done, 0);
    chk(req_ready == 1'b1, "R10", "ready after done", req_ready, 1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(bus_e == 1'b0 && bus_oe == 1'b0, "R1", "pins in reset", {bus_e, bus_oe}, 0);
    chk(done == 1'b0 && req_ready == 1'b1, "R1", "handshake in reset", {done, req_ready}, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_data == 8'h00 && bus_e == 1'b0, "R1", "idle after reset", rd_data, 0);

    run_txn(1'b1, 1'b0, 8'hA7, 1'b0, 1'b0, 0);  // R7 wide write, R11 no poll
    run_txn(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 0);  // R6 wide read
    run_txn(1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 0);  // R8 narrow write
    run_txn(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 0);  // R8 narrow read
    run_txn(1'b0, 1'b0, 8'h01, 1'b0, 1'b1, 3);  // R9 wide busy-wait
    run_txn(1'b1, 1'b0, 8'hF0, 1'b1, 1'b1, 2);  // R9 narrow busy-wait
    run_txn(1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1);  // R8 narrow status read
    run_txn(1'b0, 1'b0, 8'h80, 1'b0, 1'b1, 0);  // R9 not busy at once
    run_txn(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 2);  // R9 reads never poll
    run_txn(1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 3);  // R11 busy ignored without poll

    for (int k = 0; k < 25; k++) begin
      logic rs_r, rw_r, nib_r, poll_r;
      int   busy_r;
      rs_r   = $urandom; rw_r = $urandom; nib_r = $urandom; poll_r = $urandom;
      busy_r = rw_r ? int'($urandom % 2) : int'($urandom % 4);
      run_txn(rs_r, rw_r, 8'($urandom), nib_r, poll_r, busy_r);
    end
    finish_run();
  end
endmodule